// File: doc/BRIEF.md
# Byte-Lane Memory Chip-Select Decoder

This block connects a processor bus with 16 data bits to a memory array built from byte-wide SRAM chips. The processor gives a word address (its lowest address line is A1, there is no A0), two active-low byte-lane strobes, an active-low address strobe and a read/write level. The block turns these into per-chip enables, a shared chip address, per-chip output enables and per-chip write enables. It also returns a transfer acknowledge once a fixed access latency has passed.

Chips come in pairs. In each pair one chip carries the high data byte (bits 15..8) and the other carries the low byte (bits 7..0). The address bits above the chip address width pick the pair. With the default sizes the chips are 4M x 8, so the chip address is 22 bits. A single pair-select bit (A23) then gives two pairs, four chips and 16 MB. A byte access enables only the chip of its own lane. A word access enables both chips of the selected pair.

Top module: `bytelane_cs_decoder`

## Requirements
- R1: `chip_addr` equals the low `CHIP_AW` bits of `bus_addr`. Bit 0 of `bus_addr` is processor line A1, so with default sizes `chip_addr` carries A22..A1.
- R2: The top `WADDR_W-CHIP_AW` bits of `bus_addr` give the pair number p. In p the chip at index 2p serves the low lane and the chip at index 2p+1 serves the high lane. No chip of any other pair is enabled.
- R3: A chip enable (`chip_ce_n`, low = enabled) is low only while `adr_strb_n` is low, the chip's pair is selected and the chip's lane strobe is low.
- R4: While `rd_wr` is 0 (write), `chip_we_n` is low exactly on the enabled chips and every `chip_oe_n` is high.
- R5: While `rd_wr` is 1 (read), `chip_oe_n` is low exactly on the enabled chips and every `chip_we_n` is high.
- R6: A byte access keeps the enable, output enable and write enable of the chip in the other lane high. `hi_strb_n` gates the odd chips and `lo_strb_n` gates the even chips.
- R7: `xfer_ack_n` goes low after `ACK_LAT` rising clock edges during which a selected access has been held unbroken. It stays high before that.
- R8: `xfer_ack_n` goes high as soon as `adr_strb_n` returns high. The next access needs the full `ACK_LAT` edges again, even if the previous one was dropped early.
- R9: With `adr_strb_n` low and both lane strobes high, no chip is enabled and `xfer_ack_n` stays high.
- R10: While `rst_n` is low, `xfer_ack_n` stays high whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | WADDR_W | Word address; bit 0 is line A1 |
| hi_strb_n | input | 1 | High byte lane strobe (bits 15..8), active low |
| lo_strb_n | input | 1 | Low byte lane strobe (bits 7..0), active low |
| adr_strb_n | input | 1 | Address strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| chip_ce_n | output | 2*2^(WADDR_W-CHIP_AW) | Per-chip enable, active low |
| chip_addr | output | CHIP_AW | Address shared by all chips |
| chip_oe_n | output | 2*2^(WADDR_W-CHIP_AW) | Per-chip output enable, active low |
| chip_we_n | output | 2*2^(WADDR_W-CHIP_AW) | Per-chip write enable, active low |
| xfer_ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The decode path holds no state, so a wrong pair or lane mapping appears on `chip_ce_n`, `chip_oe_n` or `chip_we_n` in the same cycle the bus inputs change. It corrupts the wrong byte of memory on that access. The only state is the latency counter. If it is not cleared or does not saturate, `xfer_ack_n` falls one or more edges early or late on the next access, or never falls. The bench therefore samples the acknowledge at every edge count up to one past the latency, including right after an aborted access.

// File: rtl/cs_dec_pkg.sv
// Package: shared constants and helpers for the byte-lane chip-select decoder.
// Assumes chips are paired, with lane 0 = low byte and lane 1 = high byte.
package cs_dec_pkg;
    localparam int LANES       = 2;
    localparam int LANE_LO_IDX = 0;
    localparam int LANE_HI_IDX = 1;

    // Flat chip index of a given lane inside a given pair.
    function automatic int chip_slot(input int pair, input int lane);
        return pair * LANES + lane;
    endfunction
endpackage

// File: rtl/cs_pair_select.sv
// Module: cs_pair_select
// Splits the word address into the shared chip address and the pair-select
// field. Produces a one-hot pair select that is active only while the
// address strobe is asserted.
// Assumes WADDR_W > CHIP_AW.
module cs_pair_select #(
    parameter int WADDR_W = 23,
    parameter int CHIP_AW = 22,
    localparam int SEL_W     = WADDR_W - CHIP_AW,
    localparam int NUM_PAIRS = 1 << SEL_W
) (
    input  logic [WADDR_W-1:0]   bus_addr,
    input  logic                 adr_active,
    output logic [NUM_PAIRS-1:0] pair_sel,
    output logic [CHIP_AW-1:0]   chip_addr
);
    logic [SEL_W-1:0] sel_field;

    // Pass the low address bits to every chip; keep the top bits for selection.
    always_comb begin
        chip_addr = bus_addr[CHIP_AW-1:0];
        sel_field = bus_addr[WADDR_W-1:CHIP_AW];
    end

    // One comparator per pair, generated from the pair count.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam logic [SEL_W-1:0] PIDX = SEL_W'(p);
        always_comb begin
            pair_sel[p] = adr_active && (sel_field == PIDX);
        end
    end
endmodule

// File: rtl/cs_lane_gate.sv
// Module: cs_lane_gate
// Gates each selected pair with the two byte-lane strobes and steers the
// result to an output enable (read) or a write enable (write).
// Assumes pair_sel is one-hot or zero; all outputs are active low.
module cs_lane_gate
    import cs_dec_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    localparam int NUM_CHIPS = NUM_PAIRS * LANES
) (
    input  logic [NUM_PAIRS-1:0] pair_sel,
    input  logic                 hi_strb_n,
    input  logic                 lo_strb_n,
    input  logic                 rd_wr,
    output logic [NUM_CHIPS-1:0] ce_n,
    output logic [NUM_CHIPS-1:0] oe_n,
    output logic [NUM_CHIPS-1:0] we_n
);
    logic [LANES-1:0] lane_on;

    // Collect the lane strobes into an active-high vector indexed by lane.
    always_comb begin
        lane_on[LANE_LO_IDX] = !lo_strb_n;
        lane_on[LANE_HI_IDX] = !hi_strb_n;
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int SLOT = chip_slot(p, l);
            logic sel;
            // Chip enable plus read/write steering for one chip.
            always_comb begin
                sel        = pair_sel[p] && lane_on[l];
                ce_n[SLOT] = !sel;
                oe_n[SLOT] = !(sel && rd_wr);
                we_n[SLOT] = !(sel && !rd_wr);
            end
        end
    end
endmodule

// File: rtl/cs_ack_timer.sv
// Module: cs_ack_timer
// Counts clock edges during an unbroken live access. It asserts the
// acknowledge once ACK_LAT edges have passed and clears when the access ends.
// Assumes ACK_LAT >= 1.
module cs_ack_timer #(
    parameter int ACK_LAT = 3,
    localparam int CNT_W = $clog2(ACK_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access_live,
    output logic ack_n
);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(ACK_LAT);

    logic [CNT_W-1:0] cnt;

    // Saturating edge counter, cleared by reset or by the end of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!access_live) begin
            cnt <= '0;
        end else if (cnt != LAT_C) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Acknowledge drops low only while the access is still live.
    always_comb begin
        ack_n = !(access_live && (cnt == LAT_C));
    end
endmodule

// File: rtl/bytelane_cs_decoder.sv
// Module: bytelane_cs_decoder (top)
// Decodes a word address and two byte-lane strobes onto pairs of byte-wide
// memory chips, and returns an acknowledge after a fixed latency.
// Assumes all bus inputs are synchronous to clk; outputs except ack are
// combinational from the bus.
module bytelane_cs_decoder #(
    parameter int WADDR_W = 23,
    parameter int CHIP_AW = 22,
    parameter int ACK_LAT = 3,
    localparam int NUM_PAIRS = 1 << (WADDR_W - CHIP_AW),
    localparam int NUM_CHIPS = NUM_PAIRS * cs_dec_pkg::LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WADDR_W-1:0]   bus_addr,
    input  logic                 hi_strb_n,
    input  logic                 lo_strb_n,
    input  logic                 adr_strb_n,
    input  logic                 rd_wr,
    output logic [NUM_CHIPS-1:0] chip_ce_n,
    output logic [CHIP_AW-1:0]   chip_addr,
    output logic [NUM_CHIPS-1:0] chip_oe_n,
    output logic [NUM_CHIPS-1:0] chip_we_n,
    output logic                 xfer_ack_n
);
    logic [NUM_PAIRS-1:0] pair_sel;
    logic                 access_live;

    cs_pair_select #(
        .WADDR_W(WADDR_W),
        .CHIP_AW(CHIP_AW)
    ) u_sel (
        .bus_addr  (bus_addr),
        .adr_active(!adr_strb_n),
        .pair_sel  (pair_sel),
        .chip_addr (chip_addr)
    );

    cs_lane_gate #(
        .NUM_PAIRS(NUM_PAIRS)
    ) u_gate (
        .pair_sel (pair_sel),
        .hi_strb_n(hi_strb_n),
        .lo_strb_n(lo_strb_n),
        .rd_wr    (rd_wr),
        .ce_n     (chip_ce_n),
        .oe_n     (chip_oe_n),
        .we_n     (chip_we_n)
    );

    // A live access needs a selected pair and at least one lane strobe.
    always_comb begin
        access_live = (|pair_sel) && (!hi_strb_n || !lo_strb_n);
    end

    cs_ack_timer #(
        .ACK_LAT(ACK_LAT)
    ) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .access_live(access_live),
        .ack_n      (xfer_ack_n)
    );
endmodule

// File: rtl/cs_dec_checker.sv
// Module: cs_dec_checker
// Port-level properties of the decoder, attached to the top with bind.
module cs_dec_checker #(
    parameter int WADDR_W = 23,
    parameter int CHIP_AW = 22,
    parameter int NUM_CHIPS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [WADDR_W-1:0]   bus_addr,
    input logic                 hi_strb_n,
    input logic                 lo_strb_n,
    input logic                 adr_strb_n,
    input logic                 rd_wr,
    input logic [NUM_CHIPS-1:0] chip_ce_n,
    input logic [CHIP_AW-1:0]   chip_addr,
    input logic [NUM_CHIPS-1:0] chip_oe_n,
    input logic [NUM_CHIPS-1:0] chip_we_n,
    input logic                 xfer_ack_n
);
    localparam int SEL_W = WADDR_W - CHIP_AW;

    logic bus_live;
    always_comb begin
        bus_live = !adr_strb_n && (!hi_strb_n || !lo_strb_n);
    end

    assert_no_ce_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adr_strb_n |-> (&chip_ce_n));
    assert_write_no_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_wr |-> (&chip_oe_n));
    assert_read_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wr |-> (&chip_we_n));
    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adr_strb_n |-> xfer_ack_n);
    assert_ack_needs_history_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ack_n |-> ($past(bus_live) && bus_live));
    assert_no_lane_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_strb_n && lo_strb_n) |-> (xfer_ack_n && (&chip_ce_n)));
    assert_addr_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(bus_addr) |-> $stable(chip_addr));

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        localparam logic [SEL_W-1:0] PIDX = SEL_W'(c / 2);
        if (c % 2 == 1) begin : g_hi
            assert_lane_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
                hi_strb_n |-> (chip_ce_n[c] && chip_oe_n[c] && chip_we_n[c]));
        end else begin : g_lo
            assert_lane_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
                lo_strb_n |-> (chip_ce_n[c] && chip_oe_n[c] && chip_we_n[c]));
        end
        assert_pair_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !chip_ce_n[c] |-> (bus_addr[WADDR_W-1:CHIP_AW] == PIDX));
    end
endmodule

bind bytelane_cs_decoder cs_dec_checker #(
    .WADDR_W  (WADDR_W),
    .CHIP_AW  (CHIP_AW),
    .NUM_CHIPS(NUM_CHIPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .hi_strb_n (hi_strb_n),
    .lo_strb_n (lo_strb_n),
    .adr_strb_n(adr_strb_n),
    .rd_wr     (rd_wr),
    .chip_ce_n (chip_ce_n),
    .chip_addr (chip_addr),
    .chip_oe_n (chip_oe_n),
    .chip_we_n (chip_we_n),
    .xfer_ack_n(xfer_ack_n)
);

// File: tb/bytelane_cs_decoder_test.sv
// Scoreboard bench: driver tasks push expected port values, a monitor compares.
module bytelane_cs_decoder_test;
    localparam int WADDR_W = 23;
    localparam int CHIP_AW = 22;
    localparam int ACK_LAT = 3;
    localparam int NCH     = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [WADDR_W-1:0] bus_addr = '0;
    logic               hi_strb_n = 1'b1;
    logic               lo_strb_n = 1'b1;
    logic               adr_strb_n = 1'b1;
    logic               rd_wr = 1'b1;
    logic [NCH-1:0]     chip_ce_n, chip_oe_n, chip_we_n;
    logic [CHIP_AW-1:0] chip_addr;
    logic               xfer_ack_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [NCH-1:0]     ce_n;
        logic [NCH-1:0]     oe_n;
        logic [NCH-1:0]     we_n;
        logic [CHIP_AW-1:0] addr;
        logic               ack_n;
        string              req;
    } exp_t;

    exp_t scb[$];
    event sample_ev;

    always #5 clk = ~clk;

    bytelane_cs_decoder #(
        .WADDR_W(WADDR_W), .CHIP_AW(CHIP_AW), .ACK_LAT(ACK_LAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .hi_strb_n(hi_strb_n), .lo_strb_n(lo_strb_n),
        .adr_strb_n(adr_strb_n), .rd_wr(rd_wr),
        .chip_ce_n(chip_ce_n), .chip_addr(chip_addr),
        .chip_oe_n(chip_oe_n), .chip_we_n(chip_we_n),
        .xfer_ack_n(xfer_ack_n)
    );

    // Reference model of the decode from the requirement text (R1..R6).
    function automatic exp_t model(input logic ack_exp, input string req);
        exp_t e;
        int   pair;
        e.ce_n = '1;
        pair = int'(bus_addr[WADDR_W-1]);
        if (!adr_strb_n) begin
            if (!hi_strb_n) e.ce_n[2*pair+1] = 1'b0;
            if (!lo_strb_n) e.ce_n[2*pair]   = 1'b0;
        end
        e.oe_n  = rd_wr ? e.ce_n : '1;
        e.we_n  = rd_wr ? '1 : e.ce_n;
        e.addr  = bus_addr[CHIP_AW-1:0];
        e.ack_n = ack_exp;
        e.req   = req;
        return e;
    endfunction

    // Driver: push one expected item and hand it to the monitor.
    task automatic expect_now(input logic ack_exp, input string req);
        scb.push_back(model(ack_exp, req));
        ->sample_ev;
        #2;
    endtask

    // Monitor: pop and compare once outputs have settled.
    initial begin
        forever begin
            @(sample_ev);
            #1;
            if (scb.size() != 0) begin
                exp_t e;
                e = scb.pop_front();
                checks++;
                if (chip_ce_n !== e.ce_n || chip_oe_n !== e.oe_n ||
                    chip_we_n !== e.we_n || chip_addr !== e.addr ||
                    xfer_ack_n !== e.ack_n) begin
                    failures++;
                    $display("FAIL %s: got ce=%b oe=%b we=%b addr=%h ack=%b, exp ce=%b oe=%b we=%b addr=%h ack=%b",
                        e.req, chip_ce_n, chip_oe_n, chip_we_n, chip_addr, xfer_ack_n,
                        e.ce_n, e.oe_n, e.we_n, e.addr, e.ack_n);
                end
            end
        end
    end

    // Drive a bus cycle and check each edge up to one past the latency (R7).
    task automatic run_access(input logic [WADDR_W-1:0] a, input logic h_n,
                              input logic l_n, input logic rd, input int edges,
                              input string req);
        bit live;
        @(negedge clk);
        bus_addr = a; hi_strb_n = h_n; lo_strb_n = l_n; rd_wr = rd; adr_strb_n = 1'b0;
        live = !h_n || !l_n;
        expect_now(1'b1, req);
        for (int k = 1; k <= edges; k++) begin
            @(negedge clk);
            expect_now(!(live && rst_n && k >= ACK_LAT), req);
        end
    endtask

    // Release the bus and confirm everything returns idle at once (R8).
    task automatic release_bus(input string req);
        @(negedge clk);
        adr_strb_n = 1'b1; hi_strb_n = 1'b1; lo_strb_n = 1'b1;
        expect_now(1'b1, req);
    endtask

    initial begin
        // R10: acknowledge held off while reset is low, even with a live access.
        run_access(23'h000010, 1'b0, 1'b0, 1'b1, ACK_LAT + 2, "R10");
        release_bus("R10");
        @(negedge clk); rst_n = 1'b1;
        expect_now(1'b1, "R10");

        // R1 R2 R5: word read in pair 0, address bits pass through.
        run_access(23'h12_3456, 1'b0, 1'b0, 1'b1, ACK_LAT + 1, "R5");
        release_bus("R8");
        // R2 R4: word write in pair 1 (top bit set).
        run_access(23'h7A_BCDE, 1'b0, 1'b0, 1'b0, ACK_LAT + 1, "R4");
        release_bus("R8");
        // R6: high-lane byte write in pair 1 only touches chip 3.
        run_access(23'h40_0001, 1'b0, 1'b1, 1'b0, ACK_LAT + 1, "R6");
        release_bus("R8");
        // R6: low-lane byte read in pair 0 only touches chip 0.
        run_access(23'h3F_FFFF, 1'b1, 1'b0, 1'b1, ACK_LAT + 1, "R6");
        release_bus("R8");
        // R2: low-lane write in pair 1 enables chip 2.
        run_access(23'h55_5555, 1'b1, 1'b0, 1'b0, ACK_LAT, "R2");
        release_bus("R8");
        // R9: strobe without lanes: no enables, no acknowledge.
        run_access(23'h00_0042, 1'b1, 1'b1, 1'b1, ACK_LAT + 2, "R9");
        release_bus("R9");
        // R3: lane strobes without address strobe enable nothing.
        @(negedge clk);
        bus_addr = 23'h2A_AAAA; hi_strb_n = 1'b0; lo_strb_n = 1'b0; adr_strb_n = 1'b1;
        expect_now(1'b1, "R3");
        @(negedge clk);
        expect_now(1'b1, "R3");
        release_bus("R3");
        // R8: aborted access, then a new one must wait the full latency.
        run_access(23'h11_1111, 1'b0, 1'b0, 1'b1, ACK_LAT - 1, "R8");
        release_bus("R8");
        run_access(23'h61_0000, 1'b0, 1'b0, 1'b0, ACK_LAT + 1, "R7");
        release_bus("R8");
        // R7: back-to-back accesses with a single idle cycle.
        run_access(23'h00_0000, 1'b0, 1'b1, 1'b1, ACK_LAT + 1, "R7");
        release_bus("R8");
        run_access(23'h7F_FFFF, 1'b1, 1'b0, 1'b1, ACK_LAT + 1, "R7");
        release_bus("R8");

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule